// File: doc/BRIEF.md
# Programmable Port Clock Generator

This block produces a port clock for a serialising port, timed against a reference clock. The clock comes from one of two sources. The internal source either passes the reference through at full rate or divides it by an even ratio of twice an 8-bit divisor. The external source takes a pin clock, synchronises it into the reference domain and forwards it; the divisor has no effect on it. The generated clock is presented two ways. `clk_o` is the level of the output clock. `clk_en_o` is a one-cycle enable that marks each rising edge of that clock in the reference domain.

The block is silent until software starts it. A start strobe begins counting from zero with the divisor most recently written. A stop strobe forces the output low and clears the count. A divisor write while the block runs is held until the current half-period ends, so no short pulse is produced. A divisor wider than 8 bits is truncated to its low 8 bits. The output rate scales with the reference: with a 100 MHz reference the choices are 100 MHz, or 50/n MHz for n from 1 to 255, and the slowest is ref/510.

Top module: `port_clk_gen`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `clk_o`, `clk_en_o` and `running_o` are 0.
- R2: While `running_o` is 0, `clk_o` and `clk_en_o` stay 0 whatever the divisor, source select and external pin do.
- R3: A start strobe sets `running_o` at the next clock edge. A stop strobe clears it at the next edge. If both strobes come in the same cycle, stop wins.
- R4: With the internal source and divisor n in 1..255, `clk_o` is a square wave that is high for n cycles and low for n cycles. Its first rising edge comes n edges after the start edge. `clk_en_o` is high for exactly the first cycle of each high phase.
- R5: With the internal source and divisor 0, `clk_o` and `clk_en_o` are both 1 in every cycle while the block is running.
- R6: A divisor write keeps only bits [7:0] of `div_wdata_i`. Writing 260 gives divisor 4, so the output period is 8 cycles.
- R7: A divisor written while running takes effect at the end of the current half-period. The half-period in progress completes with the old divisor, and the next half-period uses the new one.
- R8: One edge after a stop strobe, `clk_o` and `clk_en_o` are 0. A later start restarts the count from zero, so the first rising edge again comes n edges after the start.
- R9: With `src_ext_i` = 1, `clk_o` follows `ext_clk_i` two edges late. `clk_en_o` pulses once for each rising edge of the pin. The divisor value is ignored.
- R10: Divisor 255 gives an output period of 510 reference cycles, the slowest internal rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| src_ext_i | input | 1 | 1 selects the external pin as the source, 0 the internal divider |
| div_we_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | WDATA_W | Divisor write data; only the low 8 bits are kept |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe; wins over start |
| clk_o | output | 1 | Generated clock level |
| clk_en_o | output | 1 | One-cycle enable on each rising edge of the generated clock |
| running_o | output | 1 | High from start until stop or reset |

## Verification
`running_o` changes one edge after the strobe that moves it. The first internal rising edge is due n edges after the start edge. A divisor change first shows at the end of the half-period already under way. An external pin edge reaches `clk_o` and `clk_en_o` after two edges of synchronisation. A behavioural model in the bench applies the same inputs at each rising edge and predicts all three outputs. Every cycle is compared 1 ns after the edge, while inputs only change on the falling edge. Directed measurements separately count the samples from a start or a divisor write to the next enable, and between enables, against the expected n, 2n or mixed intervals.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/pclk_ctrl.sv
module pclk_ctrl #(
  parameter int DIV_W   = 8,
  parameter int WDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               div_we_i,
  input  logic [WDATA_W-1:0] div_wdata_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               tc_i,
  output logic               run_o,
  output logic               clr_o,
  output logic [DIV_W-1:0]   div_o
);
  logic [DIV_W-1:0] pend_q, pend_d, div_q;
  logic             run_q;

  // upper write bits are dropped on purpose
  generate
    if (WDATA_W > DIV_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^div_wdata_i[WDATA_W-1:DIV_W];
    end
  endgenerate

  assign pend_d = div_we_i ? div_wdata_i[DIV_W-1:0] : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i) begin
        run_q <= 1'b1;
        div_q <= pend_d;
      end else if (!run_q || tc_i) begin
        // idle: follow writes; running: swap only at half-period end
        div_q <= pend_d;
      end
    end
  end

  assign run_o = run_q;
  assign clr_o = start_i | stop_i;
  assign div_o = div_q;

  a_r6_low_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> pend_q == $past(div_wdata_i[DIV_W-1:0]));

  a_r3_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tc_o,
  output logic             phase_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q, phase_d_q;
  logic             bypass, last;

  assign bypass = (div_i == '0);
  assign last   = (cnt_q == div_i - DIV_W'(1));
  assign tc_o   = run_i && (bypass || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      phase_d_q <= 1'b0;
    end else begin
      phase_d_q <= phase_q;
      if (clr_i) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (run_i && !bypass) begin
        if (last) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign rise_o  = phase_q & ~phase_d_q;

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass) |-> cnt_q < div_i);

  a_r4_phase_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !bypass && !last) |=> $stable(phase_q));
endmodule

// File: rtl/pclk_sync.sv
module pclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= async_i;
  end

  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b0;
        else         q[i] <= q[i-1];
      end
    end
  endgenerate

  assign level_o = q[STAGES-1];
  assign rise_o  = q[STAGES-1] & ~q[STAGES];

  a_r9_rise_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/port_clk_gen.sv
module port_clk_gen
  import pclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WDATA_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_clk_i,
  input  logic               src_ext_i,
  input  logic               div_we_i,
  input  logic [WDATA_W-1:0] div_wdata_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               clk_o,
  output logic               clk_en_o,
  output logic               running_o
);
  logic             run, clr, tc, phase, div_rise, ext_lvl, ext_rise;
  logic [DIV_W-1:0] div;
  logic             int_lvl, int_en;
  clk_src_e         src;

  pclk_ctrl #(.DIV_W(DIV_W), .WDATA_W(WDATA_W)) u_ctrl (
    .clk_i, .rst_ni, .div_we_i, .div_wdata_i, .start_i, .stop_i,
    .tc_i(tc), .run_o(run), .clr_o(clr), .div_o(div)
  );

  pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .div_i(div),
    .tc_o(tc), .phase_o(phase), .rise_o(div_rise)
  );

  pclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_clk_i), .level_o(ext_lvl), .rise_o(ext_rise)
  );

  assign src     = clk_src_e'(src_ext_i);
  assign int_lvl = (div == '0) ? 1'b1 : phase;
  assign int_en  = (div == '0) ? 1'b1 : div_rise;

  always_comb begin
    clk_o    = 1'b0;
    clk_en_o = 1'b0;
    if (run) begin
      unique case (src)
        SRC_EXT: begin clk_o = ext_lvl; clk_en_o = ext_rise; end
        default: begin clk_o = int_lvl; clk_en_o = int_en;   end
      endcase
    end
  end

  assign running_o = run;

  a_r3_start_sets_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> running_o);

  a_r8_stop_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!running_o && !clk_o && !clk_en_o));

  a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> (!clk_o && !clk_en_o));

  a_r7_div_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !start_i && !stop_i && !tc) |=> $stable(div));
endmodule

// File: tb/port_clk_gen_tb_top.sv
`timescale 1ns/1ps
module port_clk_gen_tb_top;
  localparam int WDATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext = 1'b0, src = 1'b0, we = 1'b0, start = 1'b0, stop = 1'b0;
  logic [WDATA_W-1:0] wdata = '0;
  logic clk_o, clk_en_o, running_o;

  int n_tests = 0, n_fail = 0, en_seen = 0, clk_seen = 0;
  string cur_req = "R1";
  event smp;

  always #2 clk = ~clk;

  port_clk_gen #(.WDATA_W(WDATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .src_ext_i(src),
    .div_we_i(we), .div_wdata_i(wdata), .start_i(start), .stop_i(stop),
    .clk_o(clk_o), .clk_en_o(clk_en_o), .running_o(running_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_run, m_div, m_pend, m_cnt;
  bit  m_lvl, m_lvl_p;
  bit  hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_div = 0; m_pend = 0; m_cnt = 0; m_lvl = 0; m_lvl_p = 0;
      hist = '{0, 0, 0};
    end else begin
      int pn;
      bit pl;
      pn = we ? (int'(wdata) % 256) : m_pend;
      pl = m_lvl;
      if (stop) begin
        m_run = 0; m_cnt = 0; m_lvl = 0;
      end else if (start) begin
        m_run = 1; m_cnt = 0; m_lvl = 0; m_div = pn;
      end else if (m_run != 0) begin
        if (m_div == 0) m_div = pn;
        else if (m_cnt == m_div - 1) begin
          m_cnt = 0; m_lvl = !m_lvl; m_div = pn;
        end else m_cnt++;
      end else m_div = pn;
      m_pend = pn;
      m_lvl_p = pl;
      hist.push_front(ext);
      void'(hist.pop_back());
    end
    #1;
    if (rst_n) begin
      bit ec, ee;
      ec = (m_run != 0) && (src ? hist[1] : (m_div == 0 ? 1'b1 : m_lvl));
      ee = (m_run != 0) && (src ? (hist[1] && !hist[2])
                                : (m_div == 0 ? 1'b1 : (m_lvl && !m_lvl_p)));
      chk(cur_req, "clk_o", int'(clk_o), int'(ec));
      chk(cur_req, "clk_en_o", int'(clk_en_o), int'(ee));
      chk(cur_req, "running_o", int'(running_o), m_run);
      if (clk_en_o) en_seen++;
      if (clk_o) clk_seen++;
    end
    -> smp;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic write_div(int v);
    @(negedge clk) begin we = 1'b1; wdata = WDATA_W'(v); end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(smp);
  endtask

  // samples from the start edge to the first enable
  task automatic measure_first(string req, int exp);
    int k = 0;
    do begin @(smp); k++; end while (!clk_en_o && k < 2000);
    chk(req, "first rise delay", k, exp);
  endtask

  task automatic measure_next(string req, int exp);
    int k = 0;
    do begin @(smp); k++; end while (!clk_en_o && k < 2000);
    chk(req, "interval to next rise", k, exp);
  endtask

  task automatic measure_period(string req, int exp);
    int k = 0;
    while (!clk_en_o) @(smp);
    do begin @(smp); k++; end while (!clk_en_o && k < 2000);
    chk(req, "period", k, exp);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1", "clk_o in reset", int'(clk_o), 0);
    chk("R1", "running_o in reset", int'(running_o), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(smp);
    chk("R1", "clk_en_o after reset", int'(clk_en_o), 0);
    chk("R1", "running_o after reset", int'(running_o), 0);

    // R2: configured but idle, pin toggling on both sources
    cur_req = "R2";
    write_div(3);
    en_seen = 0; clk_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) begin ext = ~ext; src = (i >= 10); end
    end
    @(negedge clk) begin ext = 1'b0; src = 1'b0; end
    chk("R2", "enables while idle", en_seen, 0);
    chk("R2", "clk high while idle", clk_seen, 0);

    // R3: start and stop together, stop wins
    cur_req = "R3";
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    chk("R3", "running after start+stop", int'(running_o), 0);

    // R4: divide by 3
    cur_req = "R4";
    pulse_start();
    chk("R3", "running after start", int'(running_o), 1);
    measure_first("R4", 3);
    measure_period("R4", 6);
    idle(20);

    // R8: stop then restart
    cur_req = "R8";
    pulse_stop();
    chk("R8", "clk_o after stop", int'(clk_o), 0);
    chk("R8", "clk_en_o after stop", int'(clk_en_o), 0);
    chk("R3", "running after stop", int'(running_o), 0);
    pulse_start();
    measure_first("R8", 3);

    // R7: change 4 -> 2 while running
    cur_req = "R7";
    pulse_stop();
    write_div(4);
    pulse_start();
    measure_first("R7", 4);
    write_div(2);
    measure_next("R7", 5);
    measure_next("R7", 4);
    measure_period("R7", 4);

    // R6: truncated write
    cur_req = "R6";
    pulse_stop();
    write_div(260);
    pulse_start();
    measure_first("R6", 4);
    measure_period("R6", 8);

    // R5: bypass
    cur_req = "R5";
    pulse_stop();
    write_div(0);
    pulse_start();
    for (int i = 0; i < 12; i++) begin
      @(smp);
      chk("R5", "bypass enable", int'(clk_en_o), 1);
    end
    write_div(2);
    idle(12);

    // R10: slowest rate
    cur_req = "R10";
    pulse_stop();
    write_div(255);
    pulse_start();
    measure_first("R10", 255);
    measure_period("R10", 510);

    // R9: external source, divisor ignored
    cur_req = "R9";
    pulse_stop();
    @(negedge clk) src = 1'b1;
    write_div(5);
    pulse_start();
    begin
      int rises = 0;
      int hi[4] = '{1, 3, 2, 7};
      int lo[4] = '{1, 2, 5, 1};
      en_seen = 0;
      for (int r = 0; r < 3; r++) begin
        for (int s = 0; s < 4; s++) begin
          @(negedge clk) ext = 1'b1;
          rises++;
          repeat (hi[s] - 1) @(negedge clk);
          @(negedge clk) ext = 1'b0;
          repeat (lo[s] - 1) @(negedge clk);
        end
      end
      repeat (5) @(negedge clk);
      chk("R9", "enables per pin rise", en_seen, rises);
    end
    @(negedge clk) ext = 1'b1;
    repeat (2) @(smp);
    @(negedge clk);
    chk("R9", "clk_o follows pin", int'(clk_o), 1);
    pulse_stop();
    @(negedge clk) ext = 1'b0;
    idle(4);

    finish_up();
  end
endmodule